// File: doc/BRIEF.md
# Oversampling Conversion Sequencer

This block drives a successive-approximation converter core through a request/acknowledge handshake and turns its 12-bit codes into averaged readings. It works on a fixed three-channel list: the main input, the mid-supply offset node and the internal reference. For every channel it runs the same power-of-two number of back-to-back conversions and adds the codes in a 20-bit accumulator. It then shifts the total right by a programmed amount and keeps the result in a per-channel output register.

Each conversion has a programmable sampling window followed by a fixed conversion phase of 12.5 converter clocks. One tick of the block clock is half a converter clock, so the window is set in half-cycle units and the conversion phase is always 25 ticks. After that the block asks the core for the code and waits for the acknowledge. Straight after reset, before it will take any measurement request, the block runs a single zero-offset calibration conversion and keeps the returned code. It does not apply that code to the results.

Top module: `adc_ovs_seq`

## Requirements
- R1: After reset the block runs exactly one calibration conversion, using the current `samp_win`. During it `cal_active` and `busy` are high. The code returned is held on `offset_code`, and calibration never happens again until the next reset.
- R2: A `start` pulse is ignored while `busy` is high, both during calibration and during a measurement run. It causes no extra run and no extra `done`.
- R3: In every conversion `samp_en` is high for exactly `samp_win` ticks (a value of 0 gives one tick). `conv_en` rises on the tick after `samp_en` falls and stays high for exactly 25 ticks. `rd_req` then rises and stays high until `rd_ack`. At no time is more than one of these three outputs high.
- R4: A run visits the channels in the order `ch_sel` = 0 (main), 1 (mid-supply), 2 (reference). Each channel gets 2^k conversions, where k is `osr_log2`, and any value above 8 is treated as 8.
- R5: Each channel result is the sum of its codes shifted right by `avg_shift`, with values above 8 treated as 8, and is presented 20 bits wide.
- R6: The accumulator never overflows. 256 codes of 4095 with a shift of 0 give exactly 1048320.
- R7: 256 full-scale codes with a shift of 8 give 4095, the 12-bit full-scale code.
- R8: `osr_log2`, `avg_shift` and `samp_win` are captured when a run starts. Changing them during the run has no effect on that run's timing or results.
- R9: When the third channel completes, `done` is high for exactly one cycle, `busy` is low in that cycle, and all three results are valid. They stay unchanged until a later run overwrites them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, one tick per half converter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a three-channel measurement run |
| osr_log2 | input | 4 | log2 of conversions per channel, saturates at 8 |
| avg_shift | input | 4 | Right shift applied to each channel sum, saturates at 8 |
| samp_win | input | 8 | Sampling window in half-cycle ticks, 0 means 1 |
| rd_ack | input | 1 | Converter core acknowledge, qualifies rd_data |
| rd_data | input | 12 | Conversion code from the core |
| samp_en | output | 1 | Sampling window active |
| conv_en | output | 1 | Conversion phase active |
| rd_req | output | 1 | Request for the conversion code |
| ch_sel | output | 2 | Channel being converted: 0 main, 1 mid-supply, 2 reference |
| cal_active | output | 1 | Calibration conversion in progress |
| busy | output | 1 | Calibration or measurement run in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| offset_code | output | 12 | Code returned by the calibration conversion |
| avg_main | output | 20 | Averaged result, main input |
| avg_mid | output | 20 | Averaged result, mid-supply offset |
| avg_ref | output | 20 | Averaged result, internal reference |

## Verification
The bench covers both ends of the sampling window. A zero window must still give one tick, and an off-by-one counter would stretch or shorten every window by a tick. A maximum-depth run of full-scale codes with no shift would wrap a narrow accumulator to a small number. The same run with a shift of 8 shows whether the scaling is exact. Values of the depth and shift above 8 show whether saturation is missing, which would give a zero-length loop or an over-shifted result. Settings are changed in the middle of a run and a second start is issued. A design that did not capture its settings, or that restarted, would produce different sums or a `done` that nothing expected. The channel codes differ per channel and per sample, so a wrong channel order or a wrong sample count changes the averages.

// File: rtl/adc_ovs_pkg.sv
package adc_ovs_pkg;
  localparam int CODE_W     = 12;
  localparam int MAX_LOG    = 8;
  localparam int ACC_W      = CODE_W + MAX_LOG;
  localparam int LOG_W      = 4;
  localparam int WIN_W      = 8;
  localparam int CONV_TICKS = 25;

  typedef enum logic [1:0] {TM_IDLE, TM_SAMP, TM_CONV, TM_READ} tmr_st_t;
  typedef enum logic [1:0] {SQ_CAL, SQ_IDLE, SQ_RUN} seq_st_t;
endpackage

// File: rtl/adc_conv_timer.sv
module adc_conv_timer
  import adc_ovs_pkg::*;
#(
  parameter int WIN_W_P  = WIN_W,
  parameter int CODE_W_P = CODE_W,
  parameter int CONV_T_P = CONV_TICKS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go,
  input  logic [WIN_W_P-1:0]  win,
  input  logic                rd_ack,
  input  logic [CODE_W_P-1:0] rd_data,
  output logic                samp_en,
  output logic                conv_en,
  output logic                rd_req,
  output logic                vld,
  output logic [CODE_W_P-1:0] code
);
  localparam int CT_W = $clog2(CONV_T_P + 1);
  localparam int TW   = (WIN_W_P > CT_W) ? WIN_W_P : CT_W;

  tmr_st_t       st_q, st_d;
  logic [TW-1:0] cnt_q, cnt_d;
  logic          cap;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      TM_IDLE: if (go) begin
        st_d  = TM_SAMP;
        cnt_d = (win == '0) ? '0 : TW'(win) - 1'b1;
      end
      TM_SAMP: if (cnt_q == '0) begin
        st_d  = TM_CONV;
        cnt_d = TW'(CONV_T_P - 1);
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
      TM_CONV: if (cnt_q == '0) st_d = TM_READ;
               else cnt_d = cnt_q - 1'b1;
      TM_READ: if (rd_ack) st_d = TM_IDLE;
      default: st_d = TM_IDLE;
    endcase
  end

  assign cap = (st_q == TM_READ) && rd_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= TM_IDLE;
      cnt_q <= '0;
      vld   <= 1'b0;
      code  <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      vld   <= cap;
      if (cap) code <= rd_data;
    end
  end

  assign samp_en = (st_q == TM_SAMP);
  assign conv_en = (st_q == TM_CONV);
  assign rd_req  = (st_q == TM_READ);
endmodule

// File: rtl/adc_ovs_accum.sv
module adc_ovs_accum
  import adc_ovs_pkg::*;
#(
  parameter int CODE_W_P = CODE_W,
  parameter int ACC_W_P  = ACC_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                add,
  input  logic [CODE_W_P-1:0] din,
  output logic [ACC_W_P-1:0]  acc,
  output logic [ACC_W_P-1:0]  sum
);
  assign sum = acc + ACC_W_P'(din);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc <= '0;
    else if (clr) acc <= '0;
    else if (add) acc <= sum;
  end
endmodule

// File: rtl/adc_ovs_seq.sv
module adc_ovs_seq
  import adc_ovs_pkg::*;
#(
  parameter int CODE_W_P = CODE_W,
  parameter int MAX_LOG_P = MAX_LOG,
  parameter int LOG_W_P  = LOG_W,
  parameter int WIN_W_P  = WIN_W,
  parameter int CONV_T_P = CONV_TICKS
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [LOG_W_P-1:0]            osr_log2,
  input  logic [LOG_W_P-1:0]            avg_shift,
  input  logic [WIN_W_P-1:0]            samp_win,
  input  logic                          rd_ack,
  input  logic [CODE_W_P-1:0]           rd_data,
  output logic                          samp_en,
  output logic                          conv_en,
  output logic                          rd_req,
  output logic [1:0]                    ch_sel,
  output logic                          cal_active,
  output logic                          busy,
  output logic                          done,
  output logic [CODE_W_P-1:0]           offset_code,
  output logic [CODE_W_P+MAX_LOG_P-1:0] avg_main,
  output logic [CODE_W_P+MAX_LOG_P-1:0] avg_mid,
  output logic [CODE_W_P+MAX_LOG_P-1:0] avg_ref
);
  localparam int ACC_W_P = CODE_W_P + MAX_LOG_P;
  localparam int N_CH    = 3;
  localparam int CH_W    = $clog2(N_CH);

  seq_st_t              st_q, st_d;
  logic [CH_W-1:0]      ch_q, ch_d;
  logic [MAX_LOG_P-1:0] cnt_q, cnt_d;
  logic [LOG_W_P-1:0]   log_q, shf_q;
  logic [WIN_W_P-1:0]   win_q, tmr_win;
  logic                 infl_q, infl_d, done_d;
  logic                 cfg_ld, offs_ld, res_ld;
  logic                 go, vld, last;
  logic [CODE_W_P-1:0]  code;
  logic [MAX_LOG_P:0]   span;
  logic [ACC_W_P-1:0]   acc_q, acc_sum, result;
  logic                 acc_add, acc_clr;
  logic [ACC_W_P-1:0]   res_q [N_CH];

  function automatic logic [LOG_W_P-1:0] clamp(input logic [LOG_W_P-1:0] v);
    return (v > LOG_W_P'(MAX_LOG_P)) ? LOG_W_P'(MAX_LOG_P) : v;
  endfunction

  assign go      = (st_q != SQ_IDLE) && !infl_q;
  assign tmr_win = (st_q == SQ_CAL) ? samp_win : win_q;
  assign span    = (MAX_LOG_P+1)'(1) << log_q;
  assign last    = ({1'b0, cnt_q} == (span - 1'b1));
  assign acc_add = vld && (st_q == SQ_RUN);
  assign acc_clr = acc_add && last;
  assign result  = acc_sum >> shf_q;

  adc_conv_timer #(.WIN_W_P(WIN_W_P), .CODE_W_P(CODE_W_P), .CONV_T_P(CONV_T_P)) u_tmr (
    .clk(clk), .rst_n(rst_n), .go(go), .win(tmr_win), .rd_ack(rd_ack), .rd_data(rd_data),
    .samp_en(samp_en), .conv_en(conv_en), .rd_req(rd_req), .vld(vld), .code(code)
  );

  adc_ovs_accum #(.CODE_W_P(CODE_W_P), .ACC_W_P(ACC_W_P)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(acc_clr), .add(acc_add), .din(code),
    .acc(acc_q), .sum(acc_sum)
  );

  always_comb begin
    st_d    = st_q;
    ch_d    = ch_q;
    cnt_d   = cnt_q;
    cfg_ld  = 1'b0;
    offs_ld = 1'b0;
    res_ld  = 1'b0;
    done_d  = 1'b0;
    infl_d  = infl_q;
    if (go)  infl_d = 1'b1;
    if (vld) infl_d = 1'b0;
    case (st_q)
      SQ_CAL: if (vld) begin
        offs_ld = 1'b1;
        st_d    = SQ_IDLE;
      end
      SQ_IDLE: if (start) begin
        st_d   = SQ_RUN;
        cfg_ld = 1'b1;
        ch_d   = '0;
        cnt_d  = '0;
      end
      SQ_RUN: if (vld) begin
        if (last) begin
          res_ld = 1'b1;
          cnt_d  = '0;
          if (ch_q == CH_W'(N_CH - 1)) begin
            st_d   = SQ_IDLE;
            done_d = 1'b1;
          end else begin
            ch_d = ch_q + 1'b1;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_CAL;
      ch_q   <= '0;
      cnt_q  <= '0;
      infl_q <= 1'b0;
      done   <= 1'b0;
    end else begin
      st_q   <= st_d;
      ch_q   <= ch_d;
      cnt_q  <= cnt_d;
      infl_q <= infl_d;
      done   <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      log_q <= '0;
      shf_q <= '0;
      win_q <= '0;
    end else if (cfg_ld) begin
      log_q <= clamp(osr_log2);
      shf_q <= clamp(avg_shift);
      win_q <= samp_win;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       offset_code <= '0;
    else if (offs_ld) offset_code <= code;
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_res
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              res_q[c] <= '0;
      else if (res_ld && (ch_q == CH_W'(c)))   res_q[c] <= result;
    end
  end

  assign ch_sel     = 2'(ch_q);
  assign cal_active = (st_q == SQ_CAL);
  assign busy       = (st_q != SQ_IDLE);
  assign avg_main   = res_q[0];
  assign avg_mid    = res_q[1];
  assign avg_ref    = res_q[2];
endmodule

// File: rtl/adc_ovs_seq_chk.sv
module adc_ovs_seq_chk #(
  parameter int ACC_W_P  = 20,
  parameter int CONV_T_P = 25
) (
  input logic               clk,
  input logic               rst_n,
  input logic               samp_en,
  input logic               conv_en,
  input logic               rd_req,
  input logic               done,
  input logic               busy,
  input logic               cal_active,
  input logic               acc_add,
  input logic [ACC_W_P-1:0] acc_q,
  input logic [ACC_W_P-1:0] acc_sum
);
  localparam int LW = $clog2(CONV_T_P + 2);
  logic [LW-1:0] conv_len;
  logic          cal_over;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       conv_len <= '0;
    else if (conv_en) conv_len <= conv_len + 1'b1;
    else              conv_len <= '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cal_over <= 1'b0;
    else if (!cal_active)         cal_over <= 1'b1;
  end

  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({samp_en, conv_en, rd_req})); // R3
  AST_SAMP_TO_CONV: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(samp_en) |-> conv_en); // R3
  AST_CONV_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conv_en) |-> (conv_len == LW'(CONV_T_P))); // R3
  AST_CONV_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    conv_len <= LW'(CONV_T_P)); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    acc_add |-> (acc_sum >= acc_q)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R9
  AST_CAL_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    !(cal_over && cal_active)); // R1
endmodule

bind adc_ovs_seq adc_ovs_seq_chk #(.ACC_W_P(ACC_W_P), .CONV_T_P(CONV_T_P)) u_chk (
  .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .conv_en(conv_en), .rd_req(rd_req),
  .done(done), .busy(busy), .cal_active(cal_active), .acc_add(acc_add),
  .acc_q(acc_q), .acc_sum(acc_sum)
);

// File: tb/sim_adc_ovs_seq.sv
`timescale 1ns/1ps
module sim_adc_ovs_seq;
  logic        clk, rst_n, start, rd_ack;
  logic [3:0]  osr_log2, avg_shift;
  logic [7:0]  samp_win;
  logic [11:0] rd_data;
  logic        samp_en, conv_en, rd_req, cal_active, busy, done;
  logic [1:0]  ch_sel;
  logic [11:0] offset_code;
  logic [19:0] avg_main, avg_mid, avg_ref;

  int n_chk = 0, n_fail = 0;
  int g_resp = 0, g_pred = 0;
  int exp_win = 6;
  bit full_mode = 0;
  bit cal_seen_end = 0;
  bit finished = 0;
  int exp_q[$];
  int last_exp[3];

  adc_ovs_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .osr_log2(osr_log2), .avg_shift(avg_shift),
    .samp_win(samp_win), .rd_ack(rd_ack), .rd_data(rd_data), .samp_en(samp_en),
    .conv_en(conv_en), .rd_req(rd_req), .ch_sel(ch_sel), .cal_active(cal_active),
    .busy(busy), .done(done), .offset_code(offset_code), .avg_main(avg_main),
    .avg_mid(avg_mid), .avg_ref(avg_ref)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  function automatic int code_of(int ch, int n);
    if (full_mode) return 4095;
    return ((ch + 1) * 523 + n * 97 + 11) % 4096;
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // converter core model: one-cycle acknowledge
  initial begin
    rd_ack = 0; rd_data = 0;
    forever begin
      @(negedge clk);
      if (rd_ack) rd_ack = 0;
      else if (rd_req) begin
        rd_ack = 1;
        if (cal_active) rd_data = 12'd11;
        else begin
          rd_data = 12'(code_of(int'(ch_sel), g_resp));
          g_resp++;
        end
      end
    end
  end

  // monitor: phase timing, calibration uniqueness, scoreboard
  initial begin
    int slen = 0, clen = 0;
    bit prev_done = 0, prev_cal = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (samp_en) slen++;
        else if (slen > 0) begin
          check(slen == exp_win, "R3 sample window", slen, exp_win);
          check(conv_en == 1'b1, "R3 convert follows sample", int'(conv_en), 1);
          slen = 0;
        end
        if (conv_en) clen++;
        else if (clen > 0) begin
          check(clen == 25, "R3 convert length", clen, 25);
          check(rd_req == 1'b1, "R3 read request follows convert", int'(rd_req), 1);
          clen = 0;
        end
        if (prev_cal && !cal_active) cal_seen_end = 1;
        if (cal_active && cal_seen_end)
          check(0, "R1 calibration repeated", 1, 0);
        prev_cal = cal_active;
        if (done) begin
          check(!prev_done, "R9 done single cycle", int'(prev_done), 0);
          check(busy == 1'b0, "R9 busy low at done", int'(busy), 0);
          if (exp_q.size() < 3) check(0, "R2 unexpected done", 1, 0);
          else begin
            int e0, e1, e2;
            e0 = exp_q.pop_front(); e1 = exp_q.pop_front(); e2 = exp_q.pop_front();
            check(int'(avg_main) == e0, "R4 R5 main result", int'(avg_main), e0);
            check(int'(avg_mid)  == e1, "R4 R5 mid result",  int'(avg_mid),  e1);
            check(int'(avg_ref)  == e2, "R4 R5 ref result",  int'(avg_ref),  e2);
          end
        end
        prev_done = done;
      end
    end
  end

  // driver: predicts and runs one sequence
  task automatic run_seq(int osr, int shf, int win, bit full, bit disturb);
    int k, s;
    k = (osr > 8) ? 8 : osr;
    s = (shf > 8) ? 8 : shf;
    full_mode = full;
    for (int c = 0; c < 3; c++) begin
      int sum = 0;
      for (int i = 0; i < (1 << k); i++) begin
        sum += code_of(c, g_pred);
        g_pred++;
      end
      exp_q.push_back(sum >>> s);
      last_exp[c] = sum >>> s;
    end
    @(negedge clk);
    osr_log2 = 4'(osr); avg_shift = 4'(shf); samp_win = 8'(win);
    exp_win = (win == 0) ? 1 : win;
    start = 1;
    @(negedge clk);
    start = 0;
    if (disturb) begin
      repeat (50) @(negedge clk);
      osr_log2 = 4'd1; avg_shift = 4'd0; samp_win = 8'd9;   // R8 changes mid-run
      start = 1;                                            // R2 start while busy
      @(negedge clk);
      start = 0;
    end
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0; start = 0; osr_log2 = 0; avg_shift = 0; samp_win = 8'd6;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(busy == 1'b1, "R1 busy after reset", int'(busy), 1);
    check(cal_active == 1'b1, "R1 calibration after reset", int'(cal_active), 1);
    check(done == 1'b0, "R9 done low after reset", int'(done), 0);
    start = 1;                                   // R2 start during calibration
    @(negedge clk);
    start = 0;
    while (busy) @(negedge clk);
    repeat (5) @(negedge clk);
    check(busy == 1'b0, "R2 start ignored during calibration", int'(busy), 0);
    check(offset_code == 12'd11, "R1 offset code stored", int'(offset_code), 11);

    run_seq(0, 0, 1, 0, 0);      // single conversions
    run_seq(2, 2, 39, 0, 0);     // 19.5-cycle window
    run_seq(3, 1, 0, 0, 0);      // zero window treated as one tick
    run_seq(12, 12, 4, 0, 0);    // saturation of depth and shift to 8
    run_seq(8, 8, 2, 1, 0);      // R7 full scale restored to 4095
    run_seq(8, 0, 2, 1, 0);      // R6 1048320, no overflow
    run_seq(4, 3, 5, 0, 1);      // R8 and R2 disturbances

    repeat (60) @(negedge clk);
    check(busy == 1'b0, "R2 no rerun after ignored start", int'(busy), 0);
    check(exp_q.size() == 0, "R9 all results delivered", exp_q.size(), 0);
    check(int'(avg_main) == last_exp[0], "R9 main result held", int'(avg_main), last_exp[0]);
    check(int'(avg_mid)  == last_exp[1], "R9 mid result held",  int'(avg_mid),  last_exp[1]);
    check(int'(avg_ref)  == last_exp[2], "R9 ref result held",  int'(avg_ref),  last_exp[2]);
    check(offset_code == 12'd11, "R1 offset unchanged", int'(offset_code), 11);
    finished = 1;
    summary();
    $finish;
  end
endmodule